// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block steers the hazard handling of a five-stage, single-issue, in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register operands that the decode and execute stages are about to consume, and at the destinations that the execute, memory and writeback stages will write. From these it chooses where each of the four operands is taken from: the register file or pipeline value, the memory-stage result, or the writeback-stage result.

The unit also owns the front-end steering. A load in execute whose destination is read by the instruction in decode freezes the program counter and the fetch/decode register for one cycle and sends a bubble down into decode/execute. A jump or taken branch is resolved in execute. It redirects fetch to the target carried from execute and turns the contents of both the fetch/decode and decode/execute registers into a no-operation instruction. All outputs are combinational and are meant to be captured by the pipeline registers at the next clock edge. Write-after-read and write-after-write conflicts cannot arise in this in-order pipeline, so the unit has no logic for them.

Top module: `hz_unit`

## Requirements
- R1: Each of the four operand selects (decode rs1/rs2, execute rs1/rs2) is encoded 2'b00 for the register file or pipeline value, 2'b01 for the writeback result and 2'b10 for the memory result. The value 2'b11 never appears.
- R2: When the memory and writeback stages both write the source register, the select is 2'b10 (the memory result wins).
- R3: A source index of zero, a producer with a zero destination, or a producer whose write-enable is low never yields a forwarding select other than 2'b00 and never causes a stall.
- R4: If execute holds a load (load flag and write-enable high, nonzero destination) whose destination equals decode rs1 or rs2, and there is no taken jump, then in that cycle: pcStall=1, idExBubble=1, pcSel=2'b01, pcNext=ifPc, ifIdInstrNext=idInstr and idExInstrNext=32'h00000013.
- R5: A dependency on a non-load producer in execute, memory or writeback is resolved by forwarding alone: pcStall and idExBubble stay 0.
- R6: A taken jump/branch in execute gives pcSel=2'b10, pcNext=exJumpPc, ifIdFlush=1, idExFlush=1 and both ifIdInstrNext and idExInstrNext equal 32'h00000013.
- R7: A taken jump in the same cycle as a load-use condition cancels the stall: pcStall=0 and idExBubble=0, and R6 applies.
- R8: With no stall and no jump: pcSel=2'b00, pcNext=ifPc+4, ifIdInstrNext=ifInstr, idExInstrNext=idInstr, and all of pcStall, idExBubble, ifIdFlush and idExFlush are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rstN | input | 1 | Active-low reset, disables the property checks |
| idRs1 | input | 5 | First source index in decode |
| idRs2 | input | 5 | Second source index in decode |
| exRs1 | input | 5 | First source index in execute |
| exRs2 | input | 5 | Second source index in execute |
| exRd | input | 5 | Destination index in execute |
| exRegWe | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | 5 | Destination index in memory stage |
| memRegWe | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | 5 | Destination index in writeback |
| wbRegWe | input | 1 | Writeback instruction writes a register |
| exJumpTaken | input | 1 | Jump or branch taken, resolved in execute |
| exJumpPc | input | 32 | Redirect target from execute |
| ifPc | input | 32 | Current fetch PC |
| ifInstr | input | 32 | Instruction word being fetched |
| idInstr | input | 32 | Current content of the fetch/decode register |
| idFwdSel1 | output | 2 | Operand source for decode rs1 |
| idFwdSel2 | output | 2 | Operand source for decode rs2 |
| exFwdSel1 | output | 2 | Operand source for execute rs1 |
| exFwdSel2 | output | 2 | Operand source for execute rs2 |
| pcStall | output | 1 | Hold the PC and the fetch/decode register |
| idExBubble | output | 1 | Load-use bubble into decode/execute |
| ifIdFlush | output | 1 | Flush the fetch/decode register |
| idExFlush | output | 1 | Flush the decode/execute register |
| pcSel | output | 2 | Next-PC source: 00 sequential, 01 hold, 10 jump |
| pcNext | output | 32 | Next PC value |
| ifIdInstrNext | output | 32 | Value for the fetch/decode register at the next edge |
| idExInstrNext | output | 32 | Value for the decode/execute register at the next edge |

## Verification
The unit holds no state, so an error shows at the ports in the same cycle as the stimulus. A wrong priority between producers shows as a wrong select value. A missed load-use hazard shows as pcNext advancing by four while a bubble should have gone in. A stall that is not cancelled on a jump shows as pcNext staying at ifPc when it should be the target. The bench drives a model-computed expectation for every output on every cycle, using both directed hazard pairs and dense random index traffic over a small register range, so that matches, zero indices and collisions happen often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_REG = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_e;

  typedef enum logic [1:0] {
    PC_SEQ  = 2'b00,
    PC_HOLD = 2'b01,
    PC_JUMP = 2'b10
  } pcSel_e;

  // strobes from the control module to the datapath module
  typedef struct packed {
    logic   holdFront;
    logic   bubbleIdEx;
    logic   flushIfId;
    logic   flushIdEx;
    pcSel_e pcSel;
  } hzStrobe_t;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] srcIdx,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWe,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbRegWe,
  output fwdSel_e           sel
);
  logic srcLive;
  logic memHit;
  logic wbHit;

  assign srcLive = (srcIdx != '0);
  assign memHit  = srcLive && memRegWe && (memRd == srcIdx);
  assign wbHit   = srcLive && wbRegWe && (wbRd == srcIdx);

  always_comb begin
    if (memHit)     sel = FWD_MEM;   // younger producer first
    else if (wbHit) sel = FWD_WB;
    else            sel = FWD_REG;
  end

  // R1: encoding stays within the three legal codes
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    sel != 2'b11);
  // R3: register zero never takes a bypass
  p_zero_no_fwd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (srcIdx == '0) |-> (sel == FWD_REG));
  // R2: a memory-stage match dominates a writeback match
  p_mem_over_wb_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcLive && memRegWe && wbRegWe && memRd == srcIdx && wbRd == srcIdx)
      |-> (sel == FWD_MEM));
endmodule

// File: rtl/hz_control.sv
module hz_control
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] idRs1,
  input  logic [REG_AW-1:0] idRs2,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exRegWe,
  input  logic              exIsLoad,
  input  logic              exJumpTaken,
  output hzStrobe_t         strobe
);
  logic loadProducer;
  logic loadUse;

  assign loadProducer = exIsLoad && exRegWe && (exRd != '0);
  assign loadUse = loadProducer && ((exRd == idRs1) || (exRd == idRs2));

  always_comb begin
    strobe = '{holdFront: 1'b0, bubbleIdEx: 1'b0, flushIfId: 1'b0,
               flushIdEx: 1'b0, pcSel: PC_SEQ};
    if (exJumpTaken) begin
      // redirect wins and cancels any load-use freeze
      strobe.flushIfId = 1'b1;
      strobe.flushIdEx = 1'b1;
      strobe.pcSel     = PC_JUMP;
    end else if (loadUse) begin
      strobe.holdFront  = 1'b1;
      strobe.bubbleIdEx = 1'b1;
      strobe.pcSel      = PC_HOLD;
    end
  end

  // R7: a redirect never coexists with a freeze
  p_flush_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    exJumpTaken |-> (!strobe.holdFront && !strobe.bubbleIdEx));
  // R5: only a load in execute may freeze the front end
  p_nonload_nostall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !exIsLoad |-> !strobe.holdFront);
  // R3: a zero or non-writing destination never freezes
  p_zero_nostall_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((exRd == '0) || !exRegWe) |-> !strobe.holdFront);
  // R4: freeze and bubble travel together
  p_hold_bubble_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdFront == strobe.bubbleIdEx);
endmodule

// File: rtl/hz_datapath.sv
module hz_datapath
  import hz_pkg::*;
#(
  parameter int                   REG_AW   = 5,
  parameter int                   PC_W     = 32,
  parameter int                   INSTR_W  = 32,
  parameter logic [INSTR_W-1:0]   NOP_WORD = 'h13,
  parameter int                   PC_STEP  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  hzStrobe_t          strobe,
  input  logic [REG_AW-1:0]  idRs1,
  input  logic [REG_AW-1:0]  idRs2,
  input  logic [REG_AW-1:0]  exRs1,
  input  logic [REG_AW-1:0]  exRs2,
  input  logic [REG_AW-1:0]  memRd,
  input  logic               memRegWe,
  input  logic [REG_AW-1:0]  wbRd,
  input  logic               wbRegWe,
  input  logic [PC_W-1:0]    exJumpPc,
  input  logic [PC_W-1:0]    ifPc,
  input  logic [INSTR_W-1:0] ifInstr,
  input  logic [INSTR_W-1:0] idInstr,
  output logic [1:0]         idFwdSel1,
  output logic [1:0]         idFwdSel2,
  output logic [1:0]         exFwdSel1,
  output logic [1:0]         exFwdSel2,
  output logic [PC_W-1:0]    pcNext,
  output logic [INSTR_W-1:0] ifIdInstrNext,
  output logic [INSTR_W-1:0] idExInstrNext
);
  localparam int NUM_SRC = 4;

  logic [REG_AW-1:0] srcIdx [NUM_SRC];
  fwdSel_e           srcSel [NUM_SRC];

  assign srcIdx[0] = idRs1;
  assign srcIdx[1] = idRs2;
  assign srcIdx[2] = exRs1;
  assign srcIdx[3] = exRs2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
    hz_fwd_pick #(.REG_AW(REG_AW)) i_pick (
      .clk      (clk),
      .rstN     (rstN),
      .srcIdx   (srcIdx[g]),
      .memRd    (memRd),
      .memRegWe (memRegWe),
      .wbRd     (wbRd),
      .wbRegWe  (wbRegWe),
      .sel      (srcSel[g])
    );
  end

  assign idFwdSel1 = srcSel[0];
  assign idFwdSel2 = srcSel[1];
  assign exFwdSel1 = srcSel[2];
  assign exFwdSel2 = srcSel[3];

  always_comb begin
    case (strobe.pcSel)
      PC_JUMP: pcNext = exJumpPc;
      PC_HOLD: pcNext = ifPc;
      default: pcNext = ifPc + PC_W'(PC_STEP);
    endcase
  end

  always_comb begin
    if (strobe.flushIfId)      ifIdInstrNext = NOP_WORD;
    else if (strobe.holdFront) ifIdInstrNext = idInstr;
    else                       ifIdInstrNext = ifInstr;
  end

  assign idExInstrNext = (strobe.flushIdEx || strobe.bubbleIdEx) ? NOP_WORD : idInstr;

  // R4: a freeze keeps both the PC and the fetch/decode word
  p_hold_keeps_front_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdFront |-> (pcNext == ifPc && ifIdInstrNext == idInstr));
  // R6: a redirect loads the target and two no-ops
  p_flush_loads_nop_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushIfId |-> (pcNext == exJumpPc && ifIdInstrNext == NOP_WORD
                          && idExInstrNext == NOP_WORD));
  // R4: a bubble is a no-op in decode/execute
  p_bubble_nop_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bubbleIdEx |-> (idExInstrNext == NOP_WORD));
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int                 REG_AW   = 5,
  parameter int                 PC_W     = 32,
  parameter int                 INSTR_W  = 32,
  parameter logic [INSTR_W-1:0] NOP_WORD = 'h13,
  parameter int                 PC_STEP  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [REG_AW-1:0]  idRs1,
  input  logic [REG_AW-1:0]  idRs2,
  input  logic [REG_AW-1:0]  exRs1,
  input  logic [REG_AW-1:0]  exRs2,
  input  logic [REG_AW-1:0]  exRd,
  input  logic               exRegWe,
  input  logic               exIsLoad,
  input  logic [REG_AW-1:0]  memRd,
  input  logic               memRegWe,
  input  logic [REG_AW-1:0]  wbRd,
  input  logic               wbRegWe,
  input  logic               exJumpTaken,
  input  logic [PC_W-1:0]    exJumpPc,
  input  logic [PC_W-1:0]    ifPc,
  input  logic [INSTR_W-1:0] ifInstr,
  input  logic [INSTR_W-1:0] idInstr,
  output logic [1:0]         idFwdSel1,
  output logic [1:0]         idFwdSel2,
  output logic [1:0]         exFwdSel1,
  output logic [1:0]         exFwdSel2,
  output logic               pcStall,
  output logic               idExBubble,
  output logic               ifIdFlush,
  output logic               idExFlush,
  output logic [1:0]         pcSel,
  output logic [PC_W-1:0]    pcNext,
  output logic [INSTR_W-1:0] ifIdInstrNext,
  output logic [INSTR_W-1:0] idExInstrNext
);
  hzStrobe_t strobe;

  hz_control #(.REG_AW(REG_AW)) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .idRs1       (idRs1),
    .idRs2       (idRs2),
    .exRd        (exRd),
    .exRegWe     (exRegWe),
    .exIsLoad    (exIsLoad),
    .exJumpTaken (exJumpTaken),
    .strobe      (strobe)
  );

  hz_datapath #(
    .REG_AW   (REG_AW),
    .PC_W     (PC_W),
    .INSTR_W  (INSTR_W),
    .NOP_WORD (NOP_WORD),
    .PC_STEP  (PC_STEP)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .idRs1         (idRs1),
    .idRs2         (idRs2),
    .exRs1         (exRs1),
    .exRs2         (exRs2),
    .memRd         (memRd),
    .memRegWe      (memRegWe),
    .wbRd          (wbRd),
    .wbRegWe       (wbRegWe),
    .exJumpPc      (exJumpPc),
    .ifPc          (ifPc),
    .ifInstr       (ifInstr),
    .idInstr       (idInstr),
    .idFwdSel1     (idFwdSel1),
    .idFwdSel2     (idFwdSel2),
    .exFwdSel1     (exFwdSel1),
    .exFwdSel2     (exFwdSel2),
    .pcNext        (pcNext),
    .ifIdInstrNext (ifIdInstrNext),
    .idExInstrNext (idExInstrNext)
  );

  assign pcStall    = strobe.holdFront;
  assign idExBubble = strobe.bubbleIdEx;
  assign ifIdFlush  = strobe.flushIfId;
  assign idExFlush  = strobe.flushIdEx;
  assign pcSel      = strobe.pcSel;
endmodule

// File: tb/test_hz_unit.sv
module test_hz_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  idRs1 = '0, idRs2 = '0, exRs1 = '0, exRs2 = '0;
  logic [4:0]  exRd = '0, memRd = '0, wbRd = '0;
  logic        exRegWe = 1'b0, exIsLoad = 1'b0, memRegWe = 1'b0, wbRegWe = 1'b0;
  logic        exJumpTaken = 1'b0;
  logic [31:0] exJumpPc = '0, ifPc = '0, ifInstr = '0, idInstr = '0;
  logic [1:0]  idFwdSel1, idFwdSel2, exFwdSel1, exFwdSel2, pcSel;
  logic        pcStall, idExBubble, ifIdFlush, idExFlush;
  logic [31:0] pcNext, ifIdInstrNext, idExInstrNext;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  localparam logic [31:0] NOP = 32'h00000013;

  always #4 clk = ~clk;  // 125 MHz

  hz_unit i_hz_unit (.*);

  function automatic logic [1:0] refSel(logic [4:0] rs);
    if (rs == 0) return 2'b00;
    if (memRegWe && memRd == rs) return 2'b10;
    if (wbRegWe && wbRd == rs) return 2'b01;
    return 2'b00;
  endfunction

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive has happened; wait to the falling edge and compare every output
  task automatic step();
    bit loadUse, jump, stall;
    logic [1:0] eSel;
    logic [31:0] ePc, eIfId, eIdEx;
    @(negedge clk);
    loadUse = exIsLoad && exRegWe && exRd != 0 && (exRd == idRs1 || exRd == idRs2);
    jump = exJumpTaken;
    stall = loadUse && !jump;
    eSel = jump ? 2'b10 : (stall ? 2'b01 : 2'b00);
    ePc = jump ? exJumpPc : (stall ? ifPc : ifPc + 32'd4);
    eIfId = jump ? NOP : (stall ? idInstr : ifInstr);
    eIdEx = (jump || stall) ? NOP : idInstr;
    cmp("R1,R2,R3 idFwdSel1", 64'(idFwdSel1), 64'(refSel(idRs1)));
    cmp("R1,R2,R3 idFwdSel2", 64'(idFwdSel2), 64'(refSel(idRs2)));
    cmp("R1,R2,R3 exFwdSel1", 64'(exFwdSel1), 64'(refSel(exRs1)));
    cmp("R1,R2,R3 exFwdSel2", 64'(exFwdSel2), 64'(refSel(exRs2)));
    cmp("R4,R5,R7 stall/bubble", {62'd0, pcStall, idExBubble}, {62'd0, stall, stall});
    cmp("R6 flushes", {62'd0, ifIdFlush, idExFlush}, {62'd0, jump, jump});
    cmp("R4,R6,R8 pcSel", 64'(pcSel), 64'(eSel));
    cmp("R4,R6,R8 pcNext", 64'(pcNext), 64'(ePc));
    cmp("R4,R6,R8 ifIdInstrNext", 64'(ifIdInstrNext), 64'(eIfId));
    cmp("R4,R6,R8 idExInstrNext", 64'(idExInstrNext), 64'(eIdEx));
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    idRs1 = 0; idRs2 = 0; exRs1 = 0; exRs2 = 0; exRd = 0; memRd = 0; wbRd = 0;
    exRegWe = 0; exIsLoad = 0; memRegWe = 0; wbRegWe = 0; exJumpTaken = 0;
    ifPc = 32'h100; ifInstr = 32'h00500093; idInstr = 32'h00100113; exJumpPc = 32'h2c;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    quiet();
    ifPc = 0; ifInstr = 0; idInstr = 0;
    #1;
    step();  // reset state, all inputs idle: R8
    step();
    rstN = 1'b1;
    // R1: memory-only match on exRs1
    quiet(); exRs1 = 5; memRd = 5; memRegWe = 1; step();
    // R1: writeback-only match on idRs2
    quiet(); idRs2 = 7; wbRd = 7; wbRegWe = 1; step();
    // R2: both stages match exRs2 and idRs1
    quiet(); exRs2 = 9; idRs1 = 9; memRd = 9; wbRd = 9; memRegWe = 1; wbRegWe = 1; step();
    // R3: destination x0 with write enabled, and a match with write disabled
    quiet(); exRs1 = 0; memRd = 0; memRegWe = 1; idRs1 = 4; wbRd = 4; wbRegWe = 0; step();
    // R5: back-to-back ALU dependency, two-back dependency
    quiet(); idRs1 = 3; exRd = 3; exRegWe = 1; exRs1 = 6; wbRd = 6; wbRegWe = 1; step();
    // R4: load-use on idRs2
    quiet(); idRs2 = 12; exRd = 12; exRegWe = 1; exIsLoad = 1; step();
    // R4: load-use on idRs1
    quiet(); idRs1 = 12; exRd = 12; exRegWe = 1; exIsLoad = 1; step();
    // R3: load into x0 never stalls
    quiet(); idRs1 = 0; exRd = 0; exRegWe = 1; exIsLoad = 1; step();
    // R6: taken branch
    quiet(); exJumpTaken = 1; exJumpPc = 32'h14; step();
    // R7: branch with load-use in the same cycle
    quiet(); exJumpTaken = 1; exJumpPc = 32'h28; idRs1 = 8; exRd = 8; exRegWe = 1; exIsLoad = 1; step();
    // mixed random traffic over a small register range
    for (int i = 0; i < 3000; i++) begin
      idRs1 = 5'($urandom_range(0, 3)); idRs2 = 5'($urandom_range(0, 3));
      exRs1 = 5'($urandom_range(0, 3)); exRs2 = 5'($urandom_range(0, 3));
      exRd = 5'($urandom_range(0, 3)); memRd = 5'($urandom_range(0, 3));
      wbRd = 5'($urandom_range(0, 3));
      exRegWe = 1'($urandom); exIsLoad = 1'($urandom); memRegWe = 1'($urandom);
      wbRegWe = 1'($urandom); exJumpTaken = ($urandom_range(0, 7) == 0);
      exJumpPc = $urandom; ifPc = $urandom; ifInstr = $urandom; idInstr = $urandom;
      step();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule